// File: doc/BRIEF.md
# Shared-Multiplier Channel Gain/Offset Calculator

This block keeps, for each of eight output channels, an input word, a gain word and an offset word. From these it computes a corrected output code. A single multiplier serves every channel, so the channels that need a new result are worked through one after another, lowest channel number first. A write can reach one channel, an aligned pair, an aligned group of four or all eight channels. Every channel it reaches is queued for recalculation.

While any recalculation is queued or running, an active-low busy output is held low. The length of the busy window grows with the number of channels processed: one lead-in slot, then one slot per channel, then a shorter tail slot. Slot lengths are parameters given in clock cycles. Writes that arrive while busy is low are accepted and added to the queue.

Each time a channel's result register is rewritten, a per-channel changed flag is set. A downstream load controller reads these flags and clears them with a clear input. A format input chooses how the input and offset words are read: two's complement or straight binary.

Top module: `chan_cal_engine`

## Requirements
- R1: Writing an input, gain or offset word (wr_sel 0, 1, 2 respectively) to a channel causes that channel's result to be recomputed as saturate(x*(m+1)/2^N + c - 2^(N-1)), with the division rounding down. Here x and c are the stored offset-binary input and offset, and m is the gain. At reset x=0, m=2^N-1, c=2^(N-1).
- R2: wr_scope selects the channels a write reaches: 0 reaches channel wr_ch only, 1 reaches the pair {wr_ch[2:1],0..1}, 2 reaches the quad {wr_ch[2],0..3}, 3 reaches all eight.
- R3: At most one channel is calculated at a time, in ascending channel order. For a write accepted at clock edge E from idle, the j-th selected channel (j from 0) has its result written at edge E+(j+2)*C_CH.
- R4: For a write from idle reaching k channels, busy_n goes low after the write edge and stays low for (k+1)*C_CH + C_TAIL cycles.
- R5: Writes accepted while busy_n is low are queued. Busy stays low until the queued channels are calculated as well.
- R6: busy_n is high only when no channel is waiting for calculation.
- R7: With fmt_twos high, input and offset words are two's complement and are stored with their MSB inverted. The gain word is always straight binary.
- R8: Results below 0 saturate to 0. Results above 2^N-1 saturate to 2^N-1.
- R9: A channel's flag in chg_flags is set on the edge its result register is written. A chg_clr bit clears that flag; when a set and a clear meet, the set wins.
- R10: A write with wr_sel 3 changes no register, queues nothing and leaves busy_n high.
- R11: After reset busy_n is high, every result is 0 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_scope | input | 2 | Channel reach: single, pair, quad, all |
| wr_ch | input | 3 | Channel number used by the reach |
| wr_sel | input | 2 | Target word: 0 input, 1 gain, 2 offset, 3 none |
| wr_data | input | N | Write data |
| fmt_twos | input | 1 | High: input and offset data are two's complement |
| chg_clr | input | 8 | Per-channel changed flag clear |
| busy_n | output | 1 | Low while calculations are queued or running |
| chg_flags | output | 8 | Per-channel result-changed flags |
| result_bus | output | 8*N | Results, channel i at bits [i*N +: N] |

## Verification
For a write from idle, the j-th reached channel's result and flag land at the write edge plus (j+2)*C_CH cycles. busy_n returns high at the write edge plus (k+1)*C_CH + C_TAIL cycles. The scoreboard stores each expected item with its due edge number and compares it in the half cycle after that edge. The busy length is measured from the recorded write edge to the first half cycle in which busy_n is seen high. Queued writes are checked for value and order only, with their busy length measured from the first write.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    SEL_INPUT  = 2'd0,
    SEL_GAIN   = 2'd1,
    SEL_OFFSET = 2'd2,
    SEL_NONE   = 2'd3
  } word_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_CALC = 2'd2,
    ST_TAIL = 2'd3
  } seq_st_e;
endpackage

// File: rtl/chan_sel_decode.sv
module chan_sel_decode #(
  parameter int NCH = 8,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            en,
  input  logic [1:0]      scope,
  input  logic [CH_W-1:0] ch,
  output logic [NCH-1:0]  mask
);
  int sh;
  always_comb begin
    if (scope == 2'd3) sh = CH_W;
    else               sh = int'(scope);
    for (int i = 0; i < NCH; i++)
      mask[i] = en && ((i >> sh) == (int'(ch) >> sh));
  end
endmodule

// File: rtl/chan_word_bank.sv
module chan_word_bank
  import cal_pkg::*;
#(
  parameter int NCH = 8,
  parameter int N   = 14,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  word_sel_e        wr_sel,
  input  logic [NCH-1:0]   wr_mask,
  input  logic [N-1:0]     wr_word,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [N-1:0]     rd_x,
  output logic [N-1:0]     rd_m,
  output logic [N-1:0]     rd_c,
  input  logic             res_we,
  input  logic [CH_W-1:0]  res_ch,
  input  logic [N-1:0]     res_val,
  input  logic [NCH-1:0]   chg_clr,
  output logic [NCH-1:0]   chg_flags,
  output logic [NCH*N-1:0] res_flat
);
  localparam logic [N-1:0] MID = {1'b1, {(N-1){1'b0}}};

  logic [NCH*N-1:0] x_flat, m_flat, c_flat;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [N-1:0] x_r, m_r, c_r, r_r;
    logic         chg_r;
    logic         hit;
    assign hit = res_we && (res_ch == CH_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_r   <= '0;
        m_r   <= '1;
        c_r   <= MID;
        r_r   <= '0;
        chg_r <= 1'b0;
      end else begin
        if (wr_mask[g]) begin
          case (wr_sel)
            SEL_INPUT:  x_r <= wr_word;
            SEL_GAIN:   m_r <= wr_word;
            SEL_OFFSET: c_r <= wr_word;
            default:    ;
          endcase
        end
        if (hit) r_r <= res_val;
        chg_r <= hit | (chg_r & ~chg_clr[g]);
      end
    end

    assign x_flat[g*N +: N]   = x_r;
    assign m_flat[g*N +: N]   = m_r;
    assign c_flat[g*N +: N]   = c_r;
    assign res_flat[g*N +: N] = r_r;
    assign chg_flags[g]       = chg_r;
  end

  assign rd_x = x_flat[rd_ch*N +: N];
  assign rd_m = m_flat[rd_ch*N +: N];
  assign rd_c = c_flat[rd_ch*N +: N];
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath #(
  parameter int N = 14
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] m,
  input  logic [N-1:0] c,
  output logic [N-1:0] y
);
  localparam logic signed [N+2:0] MIDS = (N+3)'(2**(N-1));
  localparam logic signed [N+2:0] TOPS = (N+3)'((2**N) - 1);

  function automatic logic [N-1:0] cal_code(input logic [N-1:0] xi,
                                            input logic [N-1:0] mi,
                                            input logic [N-1:0] ci);
    logic [2*N:0]      prod;
    logic [N:0]        scaled;
    logic signed [N+2:0] acc;
    prod   = (2*N+1)'(xi) * (2*N+1)'((N+1)'(mi) + (N+1)'(1));
    scaled = prod[2*N:N];
    acc    = signed'({2'b00, scaled}) + signed'({3'b000, ci}) - MIDS;
    if (acc < 0)         cal_code = '0;
    else if (acc > TOPS) cal_code = '1;
    else                 cal_code = acc[N-1:0];
  endfunction

  assign y = cal_code(x, m, c);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int C_CH   = 75,
  parameter int C_TAIL = 38,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  new_mask,
  output logic            busy_n,
  output logic [NCH-1:0]  take_mask,
  output logic [NCH-1:0]  pend_mask,
  output logic            res_we,
  output logic [CH_W-1:0] cur_ch
);
  localparam int CMAX  = (C_CH > C_TAIL) ? C_CH : C_TAIL;
  localparam int CNT_W = $clog2(CMAX + 1);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NCH-1:0]   pend_q, pend_all;
  logic [CH_W-1:0]  ch_q, pick;
  logic             any, ch_end, tl_end, launch;

  function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] v);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (v[i]) lowest = CH_W'(i);
  endfunction

  always_comb begin
    pend_all = pend_q | new_mask;
    any      = |pend_all;
    ch_end   = (cnt_q == CNT_W'(C_CH - 1));
    tl_end   = (cnt_q == CNT_W'(C_TAIL - 1));
    case (st_q)
      ST_HEAD: launch = ch_end;
      ST_CALC: launch = ch_end && any;
      ST_TAIL: launch = tl_end && any;
      default: launch = 1'b0;
    endcase
    pick      = lowest(pend_all);
    take_mask = launch ? (NCH'(1) << pick) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pend_q <= '0;
      ch_q   <= '0;
    end else begin
      pend_q <= pend_all & ~take_mask;
      if (launch) begin
        st_q  <= ST_CALC;
        cnt_q <= '0;
        ch_q  <= pick;
      end else begin
        case (st_q)
          ST_IDLE: if (any) begin st_q <= ST_HEAD; cnt_q <= '0; end
          ST_HEAD: cnt_q <= cnt_q + CNT_W'(1);
          ST_CALC: begin
            if (ch_end) begin st_q <= ST_TAIL; cnt_q <= '0; end
            else cnt_q <= cnt_q + CNT_W'(1);
          end
          default: begin
            if (tl_end) begin st_q <= ST_IDLE; cnt_q <= '0; end
            else cnt_q <= cnt_q + CNT_W'(1);
          end
        endcase
      end
    end
  end

  assign busy_n    = (st_q == ST_IDLE);
  assign res_we    = (st_q == ST_CALC) && ch_end;
  assign pend_mask = pend_q;
  assign cur_ch    = ch_q;
endmodule

// File: rtl/chan_cal_engine.sv
module chan_cal_engine
  import cal_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int N      = 14,
  parameter int C_CH   = 75,
  parameter int C_TAIL = 38,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_scope,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [1:0]       wr_sel,
  input  logic [N-1:0]     wr_data,
  input  logic             fmt_twos,
  input  logic [NCH-1:0]   chg_clr,
  output logic             busy_n,
  output logic [NCH-1:0]   chg_flags,
  output logic [NCH*N-1:0] result_bus
);
  // Named internal events, observed by the bound checker.
  word_sel_e       sel_e;
  logic            dec_en;
  logic [N-1:0]    wr_word;
  logic [NCH-1:0]  wr_mask, take_mask, pend_mask;
  logic            res_we;
  logic [CH_W-1:0] res_ch;
  logic [N-1:0]    op_x, op_m, op_c, res_val;

  function automatic logic [N-1:0] to_offset(input logic [N-1:0] d,
                                             input logic twos,
                                             input word_sel_e s);
    if (twos && (s != SEL_GAIN)) to_offset = {~d[N-1], d[N-2:0]};
    else                         to_offset = d;
  endfunction

  assign sel_e   = word_sel_e'(wr_sel);
  assign dec_en  = wr_en && (sel_e != SEL_NONE);
  assign wr_word = to_offset(wr_data, fmt_twos, sel_e);

  chan_sel_decode #(.NCH(NCH)) u_dec (
    .en    (dec_en),
    .scope (wr_scope),
    .ch    (wr_ch),
    .mask  (wr_mask)
  );

  cal_sequencer #(.NCH(NCH), .C_CH(C_CH), .C_TAIL(C_TAIL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .new_mask  (wr_mask),
    .busy_n    (busy_n),
    .take_mask (take_mask),
    .pend_mask (pend_mask),
    .res_we    (res_we),
    .cur_ch    (res_ch)
  );

  chan_word_bank #(.NCH(NCH), .N(N)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_sel    (sel_e),
    .wr_mask   (wr_mask),
    .wr_word   (wr_word),
    .rd_ch     (res_ch),
    .rd_x      (op_x),
    .rd_m      (op_m),
    .rd_c      (op_c),
    .res_we    (res_we),
    .res_ch    (res_ch),
    .res_val   (res_val),
    .chg_clr   (chg_clr),
    .chg_flags (chg_flags),
    .res_flat  (result_bus)
  );

  cal_datapath #(.N(N)) u_dp (
    .x (op_x),
    .m (op_m),
    .c (op_c),
    .y (res_val)
  );
endmodule

// File: rtl/chan_cal_checker.sv
module chan_cal_checker #(
  parameter int NCH    = 8,
  parameter int C_CH   = 75,
  parameter int C_TAIL = 38,
  localparam int CH_W  = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [1:0]      wr_sel,
  input logic            busy_n,
  input logic [NCH-1:0]  chg_flags,
  input logic [NCH-1:0]  take_mask,
  input logic [NCH-1:0]  pend_mask,
  input logic            res_we,
  input logic [CH_W-1:0] res_ch
);
  localparam int MIN_BUSY = 2 * C_CH + C_TAIL;

  logic [15:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     low_len <= '0;
    else if (busy_n)                low_len <= '0;
    else if (low_len != 16'hFFFF)   low_len <= low_len + 16'd1;
  end

  AST_RESULT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> !busy_n); // R1
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_mask)); // R3
  AST_BUSY_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_len >= 16'(MIN_BUSY))); // R4
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> (pend_mask == '0)); // R6
  AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> chg_flags[$past(res_ch)]); // R9
  AST_NONE_SEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3 && busy_n) |=> busy_n); // R10
endmodule

bind chan_cal_engine chan_cal_checker #(
  .NCH(NCH), .C_CH(C_CH), .C_TAIL(C_TAIL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .busy_n    (busy_n),
  .chg_flags (chg_flags),
  .take_mask (take_mask),
  .pend_mask (pend_mask),
  .res_we    (res_we),
  .res_ch    (res_ch)
);

// File: tb/chan_cal_engine_tb.sv
module chan_cal_engine_tb;
  localparam int NCH = 8;
  localparam int N   = 14;
  localparam int C   = 75;
  localparam int T   = 38;
  localparam int FULL = (1 << N) - 1;
  localparam int HALF = 1 << (N - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_scope = '0;
  logic [2:0] wr_ch = '0;
  logic [1:0] wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic fmt_twos = 1'b0;
  logic [NCH-1:0] chg_clr = '0;
  logic busy_n;
  logic [NCH-1:0] chg_flags;
  logic [NCH*N-1:0] result_bus;

  always #4 clk = ~clk;

  chan_cal_engine u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_scope(wr_scope),
    .wr_ch(wr_ch), .wr_sel(wr_sel), .wr_data(wr_data), .fmt_twos(fmt_twos),
    .chg_clr(chg_clr), .busy_n(busy_n), .chg_flags(chg_flags),
    .result_bus(result_bus)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int ch; int val; int due; string req; } exp_t;
  exp_t sb[$];
  int mx[NCH], mm[NCH], mc[NCH];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int model(input int ch);
    longint p;
    int v;
    p = longint'(mx[ch]) * longint'(mm[ch] + 1);
    v = int'(p / (longint'(1) << N)) + mc[ch] - HALF;
    if (v < 0) v = 0;
    if (v > FULL) v = FULL;
    return v;
  endfunction

  function automatic int reach(input int scope, input int ch);
    case (scope)
      0: return 1 << ch;
      1: return 3 << (ch & 6);
      2: return 15 << (ch & 4);
      default: return 255;
    endcase
  endfunction

  // Driver: applies one write, updates the model, pushes expected items.
  task automatic do_write(input int scope, input int ch, input int sel,
                          input int data, input bit twos, input bit timed,
                          input string req, output int wedge);
    int mask, j, d;
    @(negedge clk);
    wr_en = 1'b1; wr_scope = 2'(scope); wr_ch = 3'(ch);
    wr_sel = 2'(sel); wr_data = N'(data); fmt_twos = twos;
    wedge = cyc + 1;
    mask = (sel == 3) ? 0 : reach(scope, ch);
    d = (twos && sel != 1) ? (data ^ HALF) : data;
    j = 0;
    for (int i = 0; i < NCH; i++) begin
      if (mask[i]) begin
        exp_t e;
        if (sel == 0) mx[i] = d;
        else if (sel == 1) mm[i] = d;
        else mc[i] = d;
        e.ch = i; e.val = model(i); e.req = req;
        e.due = timed ? wedge + (j + 2) * C : -1;
        sb.push_back(e);
        j++;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input int wedge, output int len);
    while (!busy_n) @(negedge clk);
    len = cyc - wedge;
  endtask

  // Monitor: pops an expected item each time a changed flag shows up.
  logic [NCH-1:0] last_clr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk((chg_flags & last_clr) == '0, "R9", "flag cleared by chg_clr",
          int'(chg_flags & last_clr), 0);
      chg_clr = '0;
      if (chg_flags != '0) begin
        chk($countones(chg_flags) == 1, "R3", "one channel per result slot",
            $countones(chg_flags), 1);
        for (int i = 0; i < NCH; i++) begin
          if (chg_flags[i]) begin
            if (sb.size() == 0) begin
              chk(1'b0, "R6", "unexpected result on channel", i, -1);
            end else begin
              exp_t e;
              int got;
              e = sb.pop_front();
              got = int'(result_bus[i*N +: N]);
              chk(e.ch == i, e.req, "channel order", i, e.ch);
              chk(got == e.val, e.req, "result value", got, e.val);
              if (e.due >= 0) chk(cyc == e.due, "R3", "result edge", cyc, e.due);
            end
          end
        end
        chg_clr = chg_flags;
      end
      last_clr = chg_clr;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int we, we2, len;
    for (int i = 0; i < NCH; i++) begin mx[i] = 0; mm[i] = FULL; mc[i] = HALF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy_n == 1'b1, "R11", "busy_n after reset", int'(busy_n), 1);
    chk(result_bus == '0, "R11", "results after reset", int'(result_bus[N-1:0]), 0);
    chk(chg_flags == '0, "R11", "flags after reset", int'(chg_flags), 0);

    // R1/R4: single channel input write
    do_write(0, 3, 0, 12288, 1'b0, 1'b1, "R1", we);
    wait_idle(we, len);
    chk(len == 2*C + T, "R4", "busy length, 1 channel", len, 2*C + T);

    // R2/R4: all eight channels, ascending order
    do_write(3, 0, 0, 10000, 1'b0, 1'b1, "R2", we);
    wait_idle(we, len);
    chk(len == 9*C + T, "R4", "busy length, 8 channels", len, 9*C + T);

    // R2: pair reach, gain word
    do_write(1, 5, 1, 8191, 1'b0, 1'b1, "R2", we);
    wait_idle(we, len);
    chk(len == 3*C + T, "R4", "busy length, 2 channels", len, 3*C + T);

    // R2: quad reach, offset word
    do_write(2, 1, 2, HALF + 1000, 1'b0, 1'b1, "R2", we);
    wait_idle(we, len);
    chk(len == 5*C + T, "R4", "busy length, 4 channels", len, 5*C + T);

    // R8: saturation high, then low
    do_write(0, 6, 2, FULL, 1'b0, 1'b1, "R8", we);
    wait_idle(we, len);
    do_write(0, 7, 0, 0, 1'b0, 1'b1, "R8", we);
    wait_idle(we, len);
    do_write(0, 7, 2, 0, 1'b0, 1'b1, "R8", we);
    wait_idle(we, len);

    // R7: two's complement input and offset, binary gain
    do_write(0, 2, 0, FULL, 1'b1, 1'b1, "R7", we);
    wait_idle(we, len);
    do_write(0, 2, 1, 8191, 1'b1, 1'b1, "R7", we);
    wait_idle(we, len);
    do_write(0, 2, 2, 0, 1'b1, 1'b1, "R7", we);
    wait_idle(we, len);

    // R10: write to no register
    do_write(3, 0, 3, 0, 1'b0, 1'b1, "R10", we);
    repeat (3) @(negedge clk);
    chk(busy_n == 1'b1, "R10", "busy_n after ignored write", int'(busy_n), 1);
    chk(int'(result_bus[N-1:0]) == 11000, "R10", "channel 0 result kept",
        int'(result_bus[N-1:0]), 11000);

    // R5: second write queued during the lead-in slot
    do_write(0, 0, 0, 2000, 1'b0, 1'b0, "R5", we);
    repeat (3) @(negedge clk);
    do_write(0, 1, 0, 4000, 1'b0, 1'b0, "R5", we2);
    chk(busy_n == 1'b0, "R5", "busy_n held during queued work", int'(busy_n), 0);
    wait_idle(we, len);
    chk(len == 3*C + T, "R5", "busy length with queued channel", len, 3*C + T);

    // R6: idle means nothing outstanding
    repeat (2*C) @(negedge clk);
    chk(sb.size() == 0, "R6", "items left in scoreboard", sb.size(), 0);
    chk(busy_n == 1'b1, "R6", "busy_n stays high when idle", int'(busy_n), 1);
    finish_run();
  end
endmodule